// File: doc/BRIEF.md
# Command-Driven I2C Controller with Clock-Stretch Wait

The block is a bus controller for a two-wire open-drain serial bus. A host hands it one command at a time: generate a start (or a repeated start while the bus is held), send a byte, receive a byte and answer it with an acknowledge or a not-acknowledge, or generate a stop. Each command ends with a one-cycle completion pulse. With that pulse the controller reports the acknowledge it sampled, the received byte, and whether it lost arbitration. 7-bit and 10-bit target selection are formed by the host as sequences of these commands.

The controller never drives a line high. Each of its two outputs is an enable that pulls a line low. The SCL timing comes from a programmable quarter-period count, `cfg_qtr`, in system clock cycles; at 200 MHz, 500 gives 100 kHz and 125 gives 400 kHz. Every clock phase is timed only after the sensed SCL level agrees with the level being driven. So a target that holds SCL low pauses the controller and does not shorten the following high phase. When the controller releases SDA for a 1 and senses it low at the rising edge of SCL, it releases both lines and ends the command.

Top module: `i2c_cmd_ctrl`

## Requirements
- R1: After reset both pull-down enables are 0, `cmd_ready` is 1 and `done` is 0.
- R2: A start command (op 2'b00) brings SDA from high to low while SCL is high, then pulls SCL low; the command completes with SCL held low.
- R3: A write command (op 2'b01) shifts `cmd_wdata` out MSB first, with one SCL high phase per bit. SDA does not change while SCL is high. SDA is released for the ninth clock, and `ack_rx` is 1 when SDA was sampled low there.
- R4: A read command (op 2'b10) keeps SDA released for eight clocks and gathers the bits MSB first into `rdata`. On the ninth clock it pulls SDA low when `cmd_ack` is 1 and leaves it released when `cmd_ack` is 0.
- R5: A stop command (op 2'b11) brings SDA from low to high while SCL is high, and leaves both lines released.
- R6: A start issued while the bus is held produces a repeated start: SDA is released while SCL is low, so no stop appears, and then exactly one start condition follows.
- R7: Each SCL high phase during a byte lasts 2×`cfg_qtr` clock cycles, counted from the moment SCL is sensed high. Values of `cfg_qtr` below 2 act as 2.
- R8: While SCL is released by the controller but held low by another device, the controller does not change SDA, and it starts timing the high phase only once SCL is sensed high.
- R9: If SDA is sensed low in a written data bit where the controller released it, the controller releases both lines and completes at once with `arb_lost` = 1. No further clocks are generated.
- R10: A command is accepted only in a cycle where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` drops in the next cycle, and `done` is a single-cycle pulse coinciding with `cmd_ready` returning to 1.
- R11: When SDA is high on the ninth clock of a write, `ack_rx` is 0, and the bus stays held so a stop or repeated start can follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_qtr | input | QW | SCL quarter period in clock cycles |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00 start, 01 write, 10 read, 11 stop |
| cmd_wdata | input | 8 | Byte to send for a write |
| cmd_ack | input | 1 | For a read: 1 answers with acknowledge |
| cmd_ready | output | 1 | Controller idle, can take a command |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte sampled by the last read or write |
| ack_rx | output | 1 | Ninth bit was sampled low |
| arb_lost | output | 1 | Last command ended by arbitration loss |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The hardest situations to reach from the ports are a target stretching the clock at a chosen bit, and another device pulling SDA low in exactly the bit where the controller sends a 1. The bench models the open-drain wires and a target that counts falling SCL edges inside each command. At a randomly chosen falling edge, it holds SCL low for a random number of cycles, and it checks that SDA stays put and that the next high phase keeps its full length. For arbitration, it writes a byte whose second bit is 1 and pulls SDA low from the first falling edge. It then expects a prompt abort with both lines free, and a clean start afterwards.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_STOP  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_STOP
    } st_e;

    localparam int unsigned BYTE_W  = 8;
    localparam logic [3:0]  ACK_BIT = 4'd8;

    typedef struct packed {
        st_e               st;
        logic [1:0]        ph;
        logic [3:0]        bitn;
        logic [BYTE_W-1:0] sh;
        op_e               op;
        logic              ack_send;
        logic              scl_oe;
        logic              sda_oe;
        logic              done;
        logic              ack_rx;
        logic              arb;
        logic [BYTE_W-1:0] rdata;
    } ctl_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines_i,
    output logic [W-1:0] lines_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
        end else begin
            stg_q[0] <= lines_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign lines_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_qtr_timer.sv
module i2c_qtr_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         first,
    output logic         expire
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] lim_m1;

    always_comb begin
        lim_m1 = (limit < W'(2)) ? W'(1) : limit - W'(1);
        first  = run && (cnt_q == '0);
        expire = run && (cnt_q == lim_m1);
        cnt_d  = cnt_q;
        if (clr || expire) cnt_d = '0;
        else if (run)      cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_cmd_ctrl.sv
module i2c_cmd_ctrl
    import i2c_cmd_pkg::*;
#(
    parameter int QW     = 16,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [QW-1:0] cfg_qtr,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [7:0]    cmd_wdata,
    input  logic          cmd_ack,
    output logic          cmd_ready,
    output logic          done,
    output logic [7:0]    rdata,
    output logic          ack_rx,
    output logic          arb_lost,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          scl_oe,
    output logic          sda_oe
);
    ctl_t d, q;
    logic scl_s, sda_s;
    logic t_first, t_expire, t_run, bitval, arb_hit;

    i2c_line_sync #(.W(2), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .lines_i({scl_i, sda_i}),
        .lines_o({scl_s, sda_s})
    );

    assign t_run = (scl_s == !q.scl_oe);

    i2c_qtr_timer #(.W(QW)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clr(q.st == ST_IDLE),
        .run(t_run),
        .limit(cfg_qtr),
        .first(t_first),
        .expire(t_expire)
    );

    always_comb begin
        if (q.bitn == ACK_BIT) bitval = (q.op == OP_READ) ? !q.ack_send : 1'b1;
        else                   bitval = (q.op == OP_WRITE) ? q.sh[7] : 1'b1;
        arb_hit = (q.st == ST_BIT) && (q.ph == 2'd2) && t_first &&
                  (q.op == OP_WRITE) && (q.bitn != ACK_BIT) && bitval && !sda_s;
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: if (cmd_valid) begin
                d.op       = op_e'(cmd_op);
                d.ack_send = cmd_ack;
                d.sh       = cmd_wdata;
                d.ph       = 2'd0;
                d.bitn     = 4'd0;
                d.arb      = 1'b0;
                unique case (op_e'(cmd_op))
                    OP_START: begin d.st = ST_START; d.sda_oe = 1'b0; end
                    OP_STOP:  begin d.st = ST_STOP;  d.scl_oe = 1'b1; end
                    default:  begin d.st = ST_BIT;   d.scl_oe = 1'b1; end
                endcase
            end
            ST_START: if (t_expire) begin
                d.ph = q.ph + 2'd1;
                unique case (q.ph)
                    2'd0: d.scl_oe = 1'b0;
                    2'd1: d.sda_oe = 1'b1;
                    2'd2: d.scl_oe = 1'b1;
                    default: begin d.done = 1'b1; d.st = ST_IDLE; end
                endcase
            end
            ST_STOP: if (t_expire) begin
                d.ph = q.ph + 2'd1;
                unique case (q.ph)
                    2'd0: d.sda_oe = 1'b1;
                    2'd1: d.scl_oe = 1'b0;
                    2'd2: d.sda_oe = 1'b0;
                    default: begin d.done = 1'b1; d.st = ST_IDLE; end
                endcase
            end
            default: begin
                if (arb_hit) begin
                    d.scl_oe = 1'b0;
                    d.sda_oe = 1'b0;
                    d.arb    = 1'b1;
                    d.done   = 1'b1;
                    d.st     = ST_IDLE;
                end else begin
                    if (q.ph == 2'd2 && t_first) begin
                        if (q.bitn == ACK_BIT) d.ack_rx = !sda_s;
                        else                   d.sh = {q.sh[6:0], sda_s};
                    end
                    if (t_expire) begin
                        d.ph = q.ph + 2'd1;
                        unique case (q.ph)
                            2'd0: d.sda_oe = !bitval;
                            2'd1: d.scl_oe = 1'b0;
                            2'd2: ;
                            default: begin
                                d.scl_oe = 1'b1;
                                if (q.bitn == ACK_BIT) begin
                                    d.done  = 1'b1;
                                    d.st    = ST_IDLE;
                                    d.rdata = q.sh;
                                end else begin
                                    d.bitn = q.bitn + 4'd1;
                                end
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.op       <= OP_START;
        end else begin
            q <= d;
        end
    end

    assign cmd_ready = (q.st == ST_IDLE);
    assign done      = q.done;
    assign rdata     = q.rdata;
    assign ack_rx    = q.ack_rx;
    assign arb_lost  = q.arb;
    assign scl_oe    = q.scl_oe;
    assign sda_oe    = q.sda_oe;
endmodule

// File: rtl/i2c_cmd_ctrl_chk.sv
module i2c_cmd_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic done,
    input logic arb_lost,
    input logic scl_i,
    input logic scl_oe,
    input logic sda_oe
);
    logic live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_RESET_FREE: assert property (@(posedge clk) !rst_n |-> (!scl_oe && !sda_oe)); // R1

    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !cmd_ready && $past(!cmd_ready) && !scl_oe && !scl_i && $past(!scl_oe && !scl_i))
        |-> $stable(sda_oe)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready); // R10

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready); // R10

    AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && arb_lost) |-> (!scl_oe && !sda_oe)); // R9
endmodule

bind i2c_cmd_ctrl i2c_cmd_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .done(done), .arb_lost(arb_lost), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module i2c_cmd_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_qtr = 16'd4;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [7:0]  cmd_wdata = 8'h00;
    logic        cmd_ack = 1'b0;
    logic        cmd_ready, done, ack_rx, arb_lost, scl_oe, sda_oe;
    logic [7:0]  rdata;
    logic        tb_scl_low = 1'b0, tb_sda_low = 1'b0, tmon = 1'b0;
    logic        scl_line, sda_line;

    assign scl_line = !(scl_oe || tb_scl_low);
    assign sda_line = !(sda_oe || tb_sda_low);

    always #2.5 clk = !clk;

    i2c_cmd_ctrl u_i2c_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_qtr(cfg_qtr), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack),
        .cmd_ready(cmd_ready), .done(done), .rdata(rdata), .ack_rx(ack_rx),
        .arb_lost(arb_lost), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int n_chk = 0, n_fail = 0, starts = 0, stops = 0, hi_bad = 0, capn = 0;
    int stretch_bad = 0, lo_meas = 0;
    logic [8:0] cap = '0;
    logic sda_oe_prev = 1'b0;
    real t_rise = 0.0;

    always @(negedge sda_line) if (scl_line === 1'b1) starts++;
    always @(posedge sda_line) if (scl_line === 1'b1) stops++;
    always @(posedge scl_line) begin
        t_rise = $realtime;
        cap = {cap[7:0], sda_line};
        capn++;
    end
    always @(negedge scl_line) begin
        if (tmon) begin
            real hl;
            hl = ($realtime - t_rise) / 5.0;
            if (hl < 2.0 * cfg_qtr || hl > 2.0 * cfg_qtr + 4.0) hi_bad++;
        end
    end
    always @(posedge clk) begin
        if (tb_scl_low && !scl_oe && sda_oe !== sda_oe_prev) stretch_bad++;
        sda_oe_prev = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] w, input logic a);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = w; cmd_ack = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
    endtask

    task automatic run_target(input int mode, input bit a, input logic [7:0] rb,
                              input int steal, input int sidx, input int slen);
        int k;
        bit fin;
        real ta;
        k = 0; fin = 0; lo_meas = 0;
        while (!fin) begin
            @(negedge scl_line or posedge done);
            if (done === 1'b1) fin = 1;
            else begin
                k++;
                if (mode == 1) tb_sda_low = (k == 8 && a) || (steal > 0 && k >= steal && k < 8);
                else           tb_sda_low = (k < 8) ? !rb[7-k] : 1'b0;
                if (k == sidx) begin
                    ta = $realtime;
                    tb_scl_low = 1'b1;
                    repeat (slen) @(posedge clk);
                    tb_scl_low = 1'b0;
                    @(posedge scl_line);
                    lo_meas = int'(($realtime - ta) / 5.0);
                end
                if (k == 9) fin = 1;
            end
        end
    endtask

    task automatic do_start(input string req);
        int s0, p0;
        s0 = starts; p0 = stops;
        issue(2'b00, 8'h00, 1'b0);
        chk(starts == s0 + 1, req, starts - s0, 1);
        chk(stops == p0, req, stops - p0, 0);
        chk(scl_line == 1'b0 && sda_line == 1'b0, "R2 lines low after start", {scl_line, sda_line}, 0);
    endtask

    task automatic do_write(input logic [7:0] w, input bit a, input int sidx, input int slen);
        int s0, p0, c0, h0, b0;
        s0 = starts; p0 = stops; c0 = capn; h0 = hi_bad; b0 = stretch_bad;
        tb_sda_low = 1'b0; tmon = 1'b1;
        fork
            run_target(1, a, 8'h00, 0, sidx, slen);
            issue(2'b01, w, 1'b0);
        join
        tmon = 1'b0; tb_sda_low = 1'b0;
        chk(capn - c0 == 9, "R3 nine clocks", capn - c0, 9);
        chk(cap[8:1] == w, "R3 bits on wire MSB first", cap[8:1], w);
        chk(ack_rx == a, a ? "R3 ack seen" : "R11 nack seen", ack_rx, a);
        chk(!arb_lost, "R9 no false loss", arb_lost, 0);
        chk(starts == s0 && stops == p0, "R3 SDA stable in SCL high", starts - s0 + stops - p0, 0);
        chk(hi_bad == h0, "R7 high phase length", hi_bad - h0, 0);
        if (sidx > 0) begin
            chk(stretch_bad == b0, "R8 SDA held during stretch", stretch_bad - b0, 0);
            chk(lo_meas >= slen, "R8 waited for stretch", lo_meas, slen);
        end
    endtask

    task automatic do_read(input logic [7:0] r, input bit a);
        int s0, p0, h0;
        s0 = starts; p0 = stops; h0 = hi_bad;
        tb_sda_low = !r[7]; tmon = 1'b1;
        fork
            run_target(2, 1'b0, r, 0, 0, 0);
            issue(2'b10, 8'h00, a);
        join
        tmon = 1'b0; tb_sda_low = 1'b0;
        chk(rdata == r, "R4 received byte", rdata, r);
        chk(cap[0] == !a, "R4 ninth bit driven per cmd_ack", cap[0], !a);
        chk(starts == s0 && stops == p0, "R4 SDA stable in SCL high", starts - s0 + stops - p0, 0);
        chk(hi_bad == h0, "R7 high phase length on read", hi_bad - h0, 0);
    endtask

    task automatic do_stop();
        int p0;
        p0 = stops;
        issue(2'b11, 8'h00, 1'b0);
        @(negedge clk);
        chk(stops == p0 + 1, "R5 stop condition", stops - p0, 1);
        chk(scl_line && sda_line && !scl_oe && !sda_oe, "R5 bus released",
            {scl_oe, sda_oe}, 0);
    endtask

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!scl_oe && !sda_oe && cmd_ready && !done, "R1 reset state",
            {scl_oe, sda_oe, cmd_ready, done}, 4'b0010);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(scl_line && sda_line, "R1 lines idle high", {scl_line, sda_line}, 3);

        // R10: handshake timing
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b00;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!cmd_ready, "R10 busy after accept", cmd_ready, 0);
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(!done && cmd_ready, "R10 done single pulse", done, 0);
        do_stop();

        // R7: slower rate directed
        cfg_qtr = 16'd25;
        do_start("R2 start at slow rate");
        do_write(8'hA5, 1'b1, 0, 0);
        do_stop();

        // R7: divider floor
        cfg_qtr = 16'd1;
        do_start("R2 start at clamped rate");
        do_write(8'h3C, 1'b0, 0, 0);
        do_stop();

        // R9: arbitration loss on second bit
        cfg_qtr = 16'd4;
        do_start("R2 start before arbitration");
        begin
            int c0;
            c0 = capn;
            tb_sda_low = 1'b0;
            fork
                run_target(1, 1'b0, 8'h00, 1, 0, 0);
                issue(2'b01, 8'h40, 1'b0);
            join
            chk(arb_lost, "R9 loss reported", arb_lost, 1);
            chk(!scl_oe && !sda_oe, "R9 both lines released", {scl_oe, sda_oe}, 0);
            repeat (40) @(negedge clk);
            chk(capn - c0 == 2, "R9 no further clocks", capn - c0, 2);
            tb_sda_low = 1'b0;
            repeat (4) @(negedge clk);
        end
        do_start("R9 start after loss");
        do_stop();

        // random transactions mixing writes, stretches, repeated starts and reads
        for (int t = 0; t < 25; t++) begin
            cfg_qtr = 16'(3 + $urandom_range(0, 3));
            do_start("R2 start");
            for (int w = 0; w < 1 + int'($urandom_range(0, 1)); w++) begin
                if ($urandom_range(0, 2) == 0)
                    do_write(8'($urandom), 1'($urandom), 1 + int'($urandom_range(0, 7)),
                             10 + int'($urandom_range(0, 29)));
                else
                    do_write(8'($urandom), 1'($urandom), 0, 0);
            end
            if ($urandom_range(0, 1) == 1) begin
                do_start("R6 repeated start");
                do_write(8'($urandom), 1'b1, 0, 0);
            end
            for (int r = 0; r < 1 + int'($urandom_range(0, 1)); r++)
                do_read(8'($urandom), 1'($urandom));
            do_stop();
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule